// File: doc/BRIEF.md
# Predicated Execution and Condition Flag Unit

This unit sits beside the execute stage of a small in-order core. For each data-processing instruction it receives the 4-bit condition field, the instruction class, the set-flags bit and a valid strobe. It tests the condition against the stored N, Z, C and V flags and reports in the same cycle whether the instruction takes effect. It also reports whether the destination register may be written.

The unit also owns the flag register. When an instruction executes and its class or set-flags bit calls for it, the flags are replaced on the next clock edge. The new values come from the candidate flags of the ALU and the barrel shifter. Which candidates are used depends on the instruction class. The arithmetic itself is done elsewhere. This unit only selects results and gates the updates.

Top module: `cond_flag_unit`

## Requirements
- R1: While `rst_n` is low, and after its release until the first update, `flags_nzcv` is 0000. The bit order is {N,Z,C,V}, with N in bit 3 and V in bit 0.
- R2: Single-flag conditions pass as follows: 0000 when Z=1, 0001 when Z=0, 0010 when C=1, 0011 when C=0, 0100 when N=1, 0101 when N=0, 0110 when V=1, 0111 when V=0.
- R3: Compound conditions pass as follows: 1000 when C=1 and Z=0; 1001 when C=0 or Z=1; 1010 when N==V; 1011 when N!=V; 1100 when Z=0 and N==V; 1101 when Z=1 or N!=V.
- R4: Condition 1110 always passes and condition 1111 never passes.
- R5: `exec_en` is high exactly when `in_valid` is high and the condition passes. With `in_valid` low, neither the flags nor `rd_we` change.
- R6: `rd_we` is high exactly when `exec_en` is high and the class is not compare. Class encoding: 00 arithmetic, 01 logical, 10 compare, 11 move.
- R7: An executed compare-class instruction updates the flags whatever the value of `set_flags`.
- R8: An executed arithmetic, logical or move instruction updates the flags only when `set_flags` is 1.
- R9: An instruction whose condition fails leaves the flags unchanged and keeps `rd_we` low.
- R10: On update, the arithmetic and compare classes load all four flags from the ALU. The logical and move classes take N and Z from the ALU, take C from `shift_c`, and keep V.
- R11: The condition is always tested against the flags held before the current instruction. The flags it writes become visible on the cycle after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is present this cycle |
| cond | input | 4 | Condition field |
| iclass | input | 2 | Instruction class |
| set_flags | input | 1 | Set-flags bit of the instruction |
| alu_n | input | 1 | ALU candidate negative flag |
| alu_z | input | 1 | ALU candidate zero flag |
| alu_c | input | 1 | ALU candidate carry flag |
| alu_v | input | 1 | ALU candidate overflow flag |
| shift_c | input | 1 | Barrel shifter carry-out |
| exec_en | output | 1 | Instruction takes effect |
| rd_we | output | 1 | Destination register write-enable |
| flags_nzcv | output | 4 | Registered flags {N,Z,C,V} |

## Verification
The assertions assume that `cond`, `iclass` and the candidate flags are known whenever `in_valid` is high. They also assume that these inputs hold steady between the driving edge and the clock edge, because `exec_en` and `rd_we` are combinational. The stimulus changes every input only at the falling edge of the clock. It draws all sixteen condition codes and all four classes uniformly. It gives the flag register a broad spread of states by letting many arithmetic instructions update it with random candidate values. Directed cases cover the never-pass code and a compare issued with the set-flags bit clear.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

   typedef enum logic [1:0] {
      CLS_ARITH = 2'b00,
      CLS_LOGIC = 2'b01,
      CLS_CMP   = 2'b10,
      CLS_MOVE  = 2'b11
   } instr_class_e;

   localparam int FLAG_N = 3;
   localparam int FLAG_Z = 2;
   localparam int FLAG_C = 1;
   localparam int FLAG_V = 0;

   localparam int EVAL_CASE = 0;
   localparam int EVAL_PAIR = 1;

endpackage

// File: rtl/cfu_cond_eval.sv
module cfu_cond_eval #(
   parameter int COND_W     = 4,
   parameter int FLAG_W     = 4,
   parameter int EVAL_STYLE = cfu_pkg::EVAL_PAIR
) (
   input  logic [COND_W-1:0] cond,
   input  logic [FLAG_W-1:0] flags,
   output logic              pass
);
   import cfu_pkg::*;

   logic fn, fz, fc, fv;
   assign fn = flags[FLAG_N];
   assign fz = flags[FLAG_Z];
   assign fc = flags[FLAG_C];
   assign fv = flags[FLAG_V];

   generate
      if (EVAL_STYLE == EVAL_CASE) begin : g_case
         always_comb begin
            unique case (cond)
               4'h0: pass = fz;
               4'h1: pass = !fz;
               4'h2: pass = fc;
               4'h3: pass = !fc;
               4'h4: pass = fn;
               4'h5: pass = !fn;
               4'h6: pass = fv;
               4'h7: pass = !fv;
               4'h8: pass = fc && !fz;
               4'h9: pass = !fc || fz;
               4'hA: pass = (fn == fv);
               4'hB: pass = (fn != fv);
               4'hC: pass = !fz && (fn == fv);
               4'hD: pass = fz || (fn != fv);
               4'hE: pass = 1'b1;
               default: pass = 1'b0;
            endcase
         end
      end else begin : g_pair
         // Odd codes are the inverse of the even code beside them.
         logic base;
         always_comb begin
            unique case (cond[COND_W-1:1])
               3'd0: base = fz;
               3'd1: base = fc;
               3'd2: base = fn;
               3'd3: base = fv;
               3'd4: base = fc && !fz;
               3'd5: base = (fn == fv);
               3'd6: base = !fz && (fn == fv);
               default: base = 1'b1;
            endcase
         end
         assign pass = cond[0] ? !base : base;
      end
   endgenerate

endmodule

// File: rtl/cfu_flag_next.sv
module cfu_flag_next #(
   parameter int FLAG_W = 4
) (
   input  logic [1:0]        iclass,
   input  logic              set_flags,
   input  logic [FLAG_W-1:0] alu_flags,
   input  logic              shift_c,
   input  logic [FLAG_W-1:0] cur_flags,
   output logic              wants_update,
   output logic [FLAG_W-1:0] next_flags
);
   import cfu_pkg::*;

   instr_class_e cls;
   assign cls = instr_class_e'(iclass);

   assign wants_update = (cls == CLS_CMP) || set_flags;

   always_comb begin
      next_flags = alu_flags;
      if (cls == CLS_LOGIC || cls == CLS_MOVE) begin
         next_flags[FLAG_C] = shift_c;
         next_flags[FLAG_V] = cur_flags[FLAG_V];
      end
   end

endmodule

// File: rtl/cfu_flag_reg.sv
module cfu_flag_reg #(
   parameter int              FLAG_W    = 4,
   parameter logic [FLAG_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [FLAG_W-1:0] d,
   output logic [FLAG_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RESET_VAL;
      else if (load) q <= d;
   end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit #(
   parameter int   COND_W      = 4,
   parameter int   EVAL_STYLE  = cfu_pkg::EVAL_PAIR,
   parameter logic [3:0] RESET_FLAGS = 4'b0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [COND_W-1:0] cond,
   input  logic [1:0]        iclass,
   input  logic              set_flags,
   input  logic              alu_n,
   input  logic              alu_z,
   input  logic              alu_c,
   input  logic              alu_v,
   input  logic              shift_c,
   output logic              exec_en,
   output logic              rd_we,
   output logic [3:0]        flags_nzcv
);
   import cfu_pkg::*;

   localparam int FLAG_W = $bits(flags_nzcv);

   generate
      if (COND_W != 4) begin : g_bad_cond
         $error("cond_flag_unit: COND_W must be 4");
      end
      if (EVAL_STYLE != EVAL_CASE && EVAL_STYLE != EVAL_PAIR) begin : g_bad_style
         $error("cond_flag_unit: unknown EVAL_STYLE");
      end
   endgenerate

   logic              pass;
   logic              wants_update;
   logic [FLAG_W-1:0] next_flags;
   logic [FLAG_W-1:0] alu_flags;

   assign alu_flags = {alu_n, alu_z, alu_c, alu_v};

   cfu_cond_eval #(
      .COND_W(COND_W), .FLAG_W(FLAG_W), .EVAL_STYLE(EVAL_STYLE)
   ) u_eval (
      .cond(cond), .flags(flags_nzcv), .pass(pass)
   );

   cfu_flag_next #(.FLAG_W(FLAG_W)) u_next (
      .iclass(iclass), .set_flags(set_flags), .alu_flags(alu_flags),
      .shift_c(shift_c), .cur_flags(flags_nzcv),
      .wants_update(wants_update), .next_flags(next_flags)
   );

   assign exec_en = in_valid && pass;
   assign rd_we   = exec_en && (instr_class_e'(iclass) != CLS_CMP);

   cfu_flag_reg #(.FLAG_W(FLAG_W), .RESET_VAL(RESET_FLAGS)) u_flags (
      .clk(clk), .rst_n(rst_n), .load(exec_en && wants_update),
      .d(next_flags), .q(flags_nzcv)
   );

endmodule

// File: rtl/cond_flag_unit_chk.sv
module cond_flag_unit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic [3:0] cond,
   input logic [1:0] iclass,
   input logic       set_flags,
   input logic       alu_n,
   input logic       alu_z,
   input logic       alu_c,
   input logic       alu_v,
   input logic       shift_c,
   input logic       exec_en,
   input logic       rd_we,
   input logic [3:0] flags_nzcv
);
   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> flags_nzcv == 4'b0000);

   assert_eq_uses_z_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cond == 4'h0) |-> exec_en == flags_nzcv[2]);

   assert_hi_compound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cond == 4'h8) |-> exec_en == (flags_nzcv[1] && !flags_nzcv[2]));

   assert_always_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cond == 4'hE) |-> exec_en);

   assert_never_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cond == 4'hF) |-> !exec_en);

   assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(flags_nzcv));

   assert_cmp_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (iclass == 2'b10) |-> !rd_we);

   assert_write_needs_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_we |-> exec_en);

   assert_cmp_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && iclass == 2'b10) |=>
         flags_nzcv == $past({alu_n, alu_z, alu_c, alu_v}));

   assert_no_s_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (iclass != 2'b10 && !set_flags) |=> $stable(flags_nzcv));

   assert_fail_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_en |=> $stable(flags_nzcv));

   assert_logic_v_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && set_flags && iclass[0]) |=>
         flags_nzcv == {$past(alu_n), $past(alu_z), $past(shift_c), $past(flags_nzcv[0])});
endmodule

bind cond_flag_unit cond_flag_unit_chk u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond(cond),
   .iclass(iclass), .set_flags(set_flags), .alu_n(alu_n), .alu_z(alu_z),
   .alu_c(alu_c), .alu_v(alu_v), .shift_c(shift_c), .exec_en(exec_en),
   .rd_we(rd_we), .flags_nzcv(flags_nzcv)
);

// File: tb/cond_flag_unit_tb_top.sv
module cond_flag_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N_RANDOM   = 4000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [3:0] cond = 4'hE;
   logic [1:0] iclass = 2'b00;
   logic       set_flags = 1'b0;
   logic       alu_n = 1'b0, alu_z = 1'b0, alu_c = 1'b0, alu_v = 1'b0;
   logic       shift_c = 1'b0;
   logic       exec_en, rd_we;
   logic [3:0] flags_nzcv;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [3:0] model = 4'b0000;

   always #(CLK_PERIOD/2) clk = ~clk;

   cond_flag_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond(cond),
      .iclass(iclass), .set_flags(set_flags), .alu_n(alu_n), .alu_z(alu_z),
      .alu_c(alu_c), .alu_v(alu_v), .shift_c(shift_c),
      .exec_en(exec_en), .rd_we(rd_we), .flags_nzcv(flags_nzcv)
   );

   function automatic bit ref_pass(input logic [3:0] c, input logic [3:0] f);
      logic n, z, cy, v;
      {n, z, cy, v} = f;
      case (c)
         4'h0: return z;          4'h1: return !z;
         4'h2: return cy;         4'h3: return !cy;
         4'h4: return n;          4'h5: return !n;
         4'h6: return v;          4'h7: return !v;
         4'h8: return cy && !z;   4'h9: return !cy || z;
         4'hA: return n == v;     4'hB: return n != v;
         4'hC: return !z && n == v;
         4'hD: return z || n != v;
         4'hE: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string cond_req(input logic [3:0] c);
      if (c < 4'h8) return "R2";
      if (c < 4'hE) return "R3";
      return "R4";
   endfunction

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   // One instruction: drive at falling edge, check enables, clock, check flags.
   task automatic issue(input bit v, input logic [3:0] c, input logic [1:0] k,
                        input bit s, input logic [3:0] alu, input bit sc);
      bit exp_exec, exp_we, upd;
      logic [3:0] nxt;
      @(negedge clk);
      in_valid = v; cond = c; iclass = k; set_flags = s;
      {alu_n, alu_z, alu_c, alu_v} = alu; shift_c = sc;
      #1;
      exp_exec = v && ref_pass(c, model);
      exp_we   = exp_exec && (k != 2'b10);
      check(v ? cond_req(c) : "R5", {3'b0, exec_en}, {3'b0, exp_exec});
      check((k == 2'b10) ? "R6 compare" : "R6", {3'b0, rd_we}, {3'b0, exp_we});
      upd = exp_exec && (k == 2'b10 || s);
      nxt = alu;
      if (k == 2'b01 || k == 2'b11) nxt = {alu[3], alu[2], sc, model[0]};
      if (upd) model = nxt;
      @(posedge clk);
      #1;
      if (!exp_exec)            check("R9 flags", flags_nzcv, model);
      else if (k == 2'b10)      check("R7 flags", flags_nzcv, model);
      else if (!s)              check("R8 flags", flags_nzcv, model);
      else if (k[0])            check("R10 logic", flags_nzcv, model);
      else                      check("R11 flags", flags_nzcv, model);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240517));
      repeat (3) @(negedge clk);
      check("R1 reset", flags_nzcv, 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after", flags_nzcv, 4'b0000);

      // Directed corner cases.
      issue(1, 4'hF, 2'b00, 1, 4'b1111, 1);   // R4 never passes
      issue(1, 4'hE, 2'b10, 0, 4'b0110, 0);   // R7 compare without S bit
      issue(1, 4'h0, 2'b00, 0, 4'b1001, 0);   // R2 EQ with Z=1, R8 no S
      issue(1, 4'h1, 2'b00, 1, 4'b0000, 0);   // R9 NE fails
      issue(0, 4'hE, 2'b10, 1, 4'b1111, 1);   // R5 invalid ignored
      issue(1, 4'hE, 2'b01, 1, 4'b1000, 1);   // R10 V kept, C from shifter
      issue(1, 4'hE, 2'b11, 1, 4'b0100, 0);   // R10 move
      issue(1, 4'hB, 2'b00, 1, 4'b0001, 0);   // R3 LT, R11 old flags
      issue(1, 4'hA, 2'b00, 1, 4'b1010, 1);   // R3 GE after update

      for (int i = 0; i < N_RANDOM; i++) begin
         logic [3:0] c;
         logic [1:0] k;
         c = 4'($urandom_range(0, 15));
         k = 2'($urandom_range(0, 3));
         issue(($urandom_range(0, 7) != 0), c, k, 1'($urandom),
               4'($urandom), 1'($urandom));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule